// File: doc/BRIEF.md
# Dual-Width Add/Subtract Status Flag Generator

This block is the add/subtract stage of a 64-bit integer datapath. It computes add, subtract-from (B minus A), the two extended forms that take the stored carry as carry-in, and negate. It also keeps the carry and overflow status that these operations leave behind. Every operation produces its carry and signed overflow at two widths at once: across the whole 64-bit word and across the low 32-bit word.

A mode input picks which width drives the primary flags. The low-word flags always follow the low 32 bits, whatever the mode. The stage also keeps a sticky summary-overflow bit. Two more opcodes complete the flag set: one loads the status from an overflow result reported by an external multiply or divide unit, and one writes the status bits explicitly.

All outputs are registered. An operation presented with `in_valid` high appears on the outputs after the next rising clock edge.

Top module: `dw_flag_alu`

## Requirements
- R1: During and after a synchronous active-high reset, `result`, `res_valid`, `so`, `ov`, `ov32`, `ca` and `ca32` are all 0.
- R2: Opcode encoding on `op`: 0 add (A+B), 1 subtract-from (~A+B+1), 2 add-extended (A+B+ca), 3 subtract-from-extended (~A+B+ca) and 4 negate (~A+1). For any of these opcodes with `in_valid` high, the clock edge loads the 64-bit sum modulo 2^64 into `result` and raises `res_valid` for one cycle. For all other opcodes `result` keeps its value.
- R3: Opcodes 0 to 3 always update `ca`. With `mode64`=1 it takes the carry out of bit 63. With `mode64`=0 it takes the carry out of bit 31 (bit 0 is the least significant bit).
- R4: Opcodes 0 to 3 always update `ca32` together with `ca`, and it takes the carry out of bit 31 in both modes.
- R5: For opcodes 0 to 3 with `ov_en`=1, `ov` takes the signed overflow of the 64-bit result when `mode64`=1 and of the low 32-bit result when `mode64`=0. `ov32` takes the low 32-bit signed overflow in both modes.
- R6: Negate with `ov_en`=1 sets both `ov` and `ov32` exactly when the operand is the most negative value of the active width: 0x8000_0000_0000_0000 with `mode64`=1, or a low word of 0x8000_0000 with `mode64`=0. Negate leaves `ca` and `ca32` unchanged.
- R7: Opcode 5 with `ov_en`=1 loads both `ov` and `ov32` from `ext_ov64` when `ext_dword`=1 and from `ext_ov32` when `ext_dword`=0. It leaves `result` and the carries unchanged.
- R8: `so` becomes 1 whenever an operation with `ov_en`=1 sets `ov`. Only an opcode 6 write clears it.
- R9: Opcode 6 loads the status from `stat_wdata`: bit 4 to `so`, bit 3 to `ov`, bit 2 to `ov32`, bit 1 to `ca` and bit 0 to `ca32`.
- R10: With `ov_en`=0, opcodes 0 to 5 leave `ov`, `ov32` and `so` unchanged. Opcode 7, or `in_valid` low, changes no output apart from clearing `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Opcode (see R2, R7, R9, R10) |
| mode64 | input | 1 | 1: 64-bit mode, 0: 32-bit mode |
| ov_en | input | 1 | Overflow recording enable |
| opa | input | W | Operand A (the complemented operand for subtract and negate) |
| opb | input | W | Operand B |
| ext_dword | input | 1 | External result is doubleword (1) or word (0) |
| ext_ov64 | input | 1 | External 64-bit overflow indication |
| ext_ov32 | input | 1 | External 32-bit overflow indication |
| stat_wdata | input | 5 | Status write value for opcode 6 |
| result | output | W | Registered sum |
| res_valid | output | 1 | Result loaded on the last edge |
| so | output | 1 | Sticky summary overflow |
| ov | output | 1 | Primary overflow |
| ov32 | output | 1 | Low-word overflow |
| ca | output | 1 | Primary carry |
| ca32 | output | 1 | Low-word carry |

## Verification
Operands are drawn from a pool of boundary values (zero, all ones, the most positive and most negative values of each width, and words whose low half alone is full or half) as well as fully random words. The carry out of the low word then differs from the carry out of the whole word, and the two overflows disagree as well. Running every pattern in both modes shows whether the primary flags really switch source while the low-word flags stay put.

Chains of extended operations show whether the stored carry feeds the next sum. Negating 0x8000_0000 in 64-bit mode separates negate's active-width rule from plain low-word overflow. Interleaved status writes and operations with overflow disabled show whether the summary bit stays sticky and is cleared only by a write.

// File: rtl/dwf_pkg.sv
package dwf_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUBF  = 3'd1,
    OP_ADDE  = 3'd2,
    OP_SUBFE = 3'd3,
    OP_NEG   = 3'd4,
    OP_XOV   = 3'd5,
    OP_WSTAT = 3'd6,
    OP_NONE  = 3'd7
  } dwf_op_e;

  localparam int unsigned STAT_W    = 5;
  localparam int unsigned BIT_SO    = 4;
  localparam int unsigned BIT_OV    = 3;
  localparam int unsigned BIT_OV32  = 2;
  localparam int unsigned BIT_CA    = 1;
  localparam int unsigned BIT_CA32  = 0;

  function automatic logic is_sum_op(input logic [2:0] o);
    return o <= 3'd4;
  endfunction

  function automatic logic is_carry_op(input logic [2:0] o);
    return o <= 3'd3;
  endfunction
endpackage

// File: rtl/dwf_operand.sv
module dwf_operand
  import dwf_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         ca_in,
  output logic [W-1:0] x,
  output logic [W-1:0] y,
  output logic         cin
);
  always_comb begin
    x   = opa;
    y   = opb;
    cin = 1'b0;
    unique case (dwf_op_e'(op))
      OP_ADD:   cin = 1'b0;
      OP_SUBF:  begin x = ~opa; cin = 1'b1; end
      OP_ADDE:  cin = ca_in;
      OP_SUBFE: begin x = ~opa; cin = ca_in; end
      OP_NEG:   begin x = ~opa; y = '0; cin = 1'b1; end
      default:  cin = 1'b0;
    endcase
  end
endmodule

// File: rtl/dwf_adder.sv
module dwf_adder #(
  parameter int unsigned W   = 64,
  parameter int unsigned LOW = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_lo,
  output logic         c_full,
  output logic         v_lo,
  output logic         v_full
);
  localparam int unsigned HIGH = W - LOW;

  logic [LOW:0]  lo_sum;
  logic [HIGH:0] hi_sum;

  always_comb begin
    lo_sum = {1'b0, x[LOW-1:0]} + {1'b0, y[LOW-1:0]} + {{LOW{1'b0}}, cin};
    hi_sum = {1'b0, x[W-1:LOW]} + {1'b0, y[W-1:LOW]} + {{HIGH{1'b0}}, lo_sum[LOW]};
    sum    = {hi_sum[HIGH-1:0], lo_sum[LOW-1:0]};
    c_lo   = lo_sum[LOW];
    c_full = hi_sum[HIGH];
    // signed overflow: equal addend signs, different result sign
    v_lo   = (x[LOW-1] == y[LOW-1]) && (sum[LOW-1] != x[LOW-1]);
    v_full = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
  end
endmodule

// File: rtl/dwf_flag_sel.sv
module dwf_flag_sel (
  input  logic mode64,
  input  logic is_neg,
  input  logic c_lo,
  input  logic c_full,
  input  logic v_lo,
  input  logic v_full,
  output logic ca_n,
  output logic ov_n,
  output logic ov32_n
);
  always_comb begin
    ca_n   = mode64 ? c_full : c_lo;
    ov_n   = mode64 ? v_full : v_lo;
    // negate reports the active-width overflow on both flags
    ov32_n = is_neg ? ov_n : v_lo;
  end
endmodule

// File: rtl/dw_flag_alu.sv
module dw_flag_alu
  import dwf_pkg::*;
#(
  parameter int unsigned W   = 64,
  parameter int unsigned LOW = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [2:0]   op,
  input  logic         mode64,
  input  logic         ov_en,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         ext_dword,
  input  logic         ext_ov64,
  input  logic         ext_ov32,
  input  logic [4:0]   stat_wdata,
  output logic [W-1:0] result,
  output logic         res_valid,
  output logic         so,
  output logic         ov,
  output logic         ov32,
  output logic         ca,
  output logic         ca32
);
  logic [W-1:0] x, y, sum;
  logic         cin, c_lo, c_full, v_lo, v_full;
  logic         ca_n, ov_n, ov32_n, ext_ov;

  dwf_operand #(.W(W)) u_opnd (
    .op(op), .opa(opa), .opb(opb), .ca_in(ca),
    .x(x), .y(y), .cin(cin)
  );

  dwf_adder #(.W(W), .LOW(LOW)) u_add (
    .x(x), .y(y), .cin(cin), .sum(sum),
    .c_lo(c_lo), .c_full(c_full), .v_lo(v_lo), .v_full(v_full)
  );

  dwf_flag_sel u_sel (
    .mode64(mode64), .is_neg(op == OP_NEG),
    .c_lo(c_lo), .c_full(c_full), .v_lo(v_lo), .v_full(v_full),
    .ca_n(ca_n), .ov_n(ov_n), .ov32_n(ov32_n)
  );

  assign ext_ov = ext_dword ? ext_ov64 : ext_ov32;

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      res_valid <= 1'b0;
      so        <= 1'b0;
      ov        <= 1'b0;
      ov32      <= 1'b0;
      ca        <= 1'b0;
      ca32      <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (in_valid) begin
        if (is_sum_op(op)) begin
          result    <= sum;
          res_valid <= 1'b1;
          if (ov_en) begin
            ov   <= ov_n;
            ov32 <= ov32_n;
            if (ov_n) so <= 1'b1;
          end
        end
        if (is_carry_op(op)) begin
          ca   <= ca_n;
          ca32 <= c_lo;
        end
        if (op == OP_XOV && ov_en) begin
          ov   <= ext_ov;
          ov32 <= ext_ov;
          if (ext_ov) so <= 1'b1;
        end
        if (op == OP_WSTAT) begin
          so   <= stat_wdata[BIT_SO];
          ov   <= stat_wdata[BIT_OV];
          ov32 <= stat_wdata[BIT_OV32];
          ca   <= stat_wdata[BIT_CA];
          ca32 <= stat_wdata[BIT_CA32];
        end
      end
    end
  end
endmodule

// File: rtl/dwf_checker.sv
module dwf_checker #(
  parameter int unsigned W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [2:0]   op,
  input logic         ov_en,
  input logic [W-1:0] result,
  input logic         res_valid,
  input logic         so,
  input logic         ov,
  input logic         ov32,
  input logic         ca,
  input logic         ca32
);
  assert_res_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op <= 3'd4) |=> res_valid);

  assert_result_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && op <= 3'd4) |=> ($stable(result) && !res_valid));

  assert_neg_keeps_carry_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd4) |=> ($stable(ca) && $stable(ca32)));

  assert_so_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (so && !(in_valid && op == 3'd6)) |=> so);

  assert_ov_sets_so_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ov_en && op <= 3'd5) |=> (!ov || so));

  assert_no_ov_update_R10: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || op == 3'd7 || (!ov_en && op != 3'd6)) |=>
      ($stable(ov) && $stable(ov32) && $stable(so)));
endmodule

bind dw_flag_alu dwf_checker #(.W(W)) i_dwf_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .ov_en(ov_en),
  .result(result), .res_valid(res_valid), .so(so), .ov(ov), .ov32(ov32),
  .ca(ca), .ca32(ca32)
);

// File: tb/test_dw_flag_alu.sv
module test_dw_flag_alu;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         d_valid = 1'b0;
  logic [2:0]   d_op = 3'd7;
  logic         d_mode = 1'b1;
  logic         d_oe = 1'b0;
  logic [W-1:0] d_a = '0;
  logic [W-1:0] d_b = '0;
  logic         d_dw = 1'b0;
  logic         d_e64 = 1'b0;
  logic         d_e32 = 1'b0;
  logic [4:0]   d_wd = '0;

  logic [W-1:0] result;
  logic         res_valid, so, ov, ov32, ca, ca32;

  dw_flag_alu #(.W(W), .LOW(32)) i_dw_flag_alu (
    .clk(clk), .rst(rst), .in_valid(d_valid), .op(d_op), .mode64(d_mode),
    .ov_en(d_oe), .opa(d_a), .opb(d_b), .ext_dword(d_dw), .ext_ov64(d_e64),
    .ext_ov32(d_e32), .stat_wdata(d_wd), .result(result),
    .res_valid(res_valid), .so(so), .ov(ov), .ov32(ov32), .ca(ca), .ca32(ca32)
  );

  always #10 clk = ~clk;

  int    n_checks = 0;
  int    n_errors = 0;
  string phase = "R1";
  bit    armed = 1'b0;
  bit    done = 1'b0;

  logic [W-1:0] m_res = '0;
  logic m_rv = 0, m_so = 0, m_ov = 0, m_ov32 = 0, m_ca = 0, m_ca32 = 0;

  function automatic bit sovf64(input logic [63:0] x, input logic [63:0] y, input logic c);
    logic signed [65:0] s;
    s = $signed({{2{x[63]}}, x}) + $signed({{2{y[63]}}, y}) + $signed({65'b0, c});
    return !(s[65:63] == 3'b000 || s[65:63] == 3'b111);
  endfunction

  function automatic bit sovf32(input logic [63:0] x, input logic [63:0] y, input logic c);
    longint s;
    s = longint'($signed(x[31:0])) + longint'($signed(y[31:0])) + longint'(c);
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    logic [63:0] x, y;
    logic        c, t;
    logic [64:0] f;
    logic [32:0] l;
    if (rst) begin
      m_res = '0; m_rv = 0; m_so = 0; m_ov = 0; m_ov32 = 0; m_ca = 0; m_ca32 = 0;
    end else begin
      m_rv = 0;
      if (d_valid) begin
        if (d_op <= 3'd3) begin
          x = (d_op[0]) ? ~d_a : d_a;
          y = d_b;
          c = (d_op == 3'd0) ? 1'b0 : (d_op == 3'd1) ? 1'b1 : m_ca;
          f = {1'b0, x} + {1'b0, y} + 65'(c);
          l = {1'b0, x[31:0]} + {1'b0, y[31:0]} + 33'(c);
          m_res = f[63:0]; m_rv = 1;
          m_ca = d_mode ? f[64] : l[32];
          m_ca32 = l[32];
          if (d_oe) begin
            m_ov = d_mode ? sovf64(x, y, c) : sovf32(x, y, c);
            m_ov32 = sovf32(x, y, c);
            if (m_ov) m_so = 1;
          end
        end else if (d_op == 3'd4) begin
          m_res = 64'd0 - d_a; m_rv = 1;
          if (d_oe) begin
            t = d_mode ? (d_a == 64'h8000_0000_0000_0000) : (d_a[31:0] == 32'h8000_0000);
            m_ov = t; m_ov32 = t;
            if (t) m_so = 1;
          end
        end else if (d_op == 3'd5) begin
          if (d_oe) begin
            t = d_dw ? d_e64 : d_e32;
            m_ov = t; m_ov32 = t;
            if (t) m_so = 1;
          end
        end else if (d_op == 3'd6) begin
          m_so = d_wd[4]; m_ov = d_wd[3]; m_ov32 = d_wd[2]; m_ca = d_wd[1]; m_ca32 = d_wd[0];
        end
      end
    end
  end

  task automatic chk(input string fld, input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s %s (phase %s) actual=%h expected=%h", req, fld, phase, got, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (armed && !done) begin
      chk("result", "R2", result, m_res);
      chk("res_valid", "R2", 64'(res_valid), 64'(m_rv));
      chk("ca", "R3", 64'(ca), 64'(m_ca));
      chk("ca32", "R4", 64'(ca32), 64'(m_ca32));
      chk("ov", "R5", 64'(ov), 64'(m_ov));
      chk("ov32", "R5", 64'(ov32), 64'(m_ov32));
      chk("so", "R8", 64'(so), 64'(m_so));
    end
  end

  task automatic op_go(input logic [2:0] o, input logic m, input logic oe,
                       input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    d_valid = 1; d_op = o; d_mode = m; d_oe = oe; d_a = a; d_b = b;
  endtask

  task automatic xov(input logic oe, input logic dw, input logic e64, input logic e32);
    @(negedge clk);
    d_valid = 1; d_op = 3'd5; d_oe = oe; d_dw = dw; d_e64 = e64; d_e32 = e32;
  endtask

  task automatic wstat(input logic [4:0] w);
    @(negedge clk);
    d_valid = 1; d_op = 3'd6; d_wd = w;
  endtask

  task automatic idle();
    @(negedge clk);
    d_valid = 0;
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 8)
      0: return 64'h0;
      1: return '1;
      2: return 64'h7FFF_FFFF_FFFF_FFFF;
      3: return 64'h8000_0000_0000_0000;
      4: return 64'h0000_0000_7FFF_FFFF;
      5: return 64'h0000_0000_8000_0000;
      6: return 64'h0000_0000_FFFF_FFFF;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    armed = 1;
    @(negedge clk);
    // R1: reset state is checked by the per-cycle compare while rst is high
    rst = 0;

    phase = "R3";    // carry out of low word only: CA differs between modes
    op_go(3'd0, 1, 0, 64'h0000_0000_FFFF_FFFF, 64'h1);
    op_go(3'd0, 0, 0, 64'h0000_0000_FFFF_FFFF, 64'h1);
    phase = "R4";
    op_go(3'd0, 1, 0, '1, 64'h1);
    phase = "R5";    // low-word overflow vs full overflow
    op_go(3'd0, 0, 1, 64'h0000_0000_7FFF_FFFF, 64'h1);
    op_go(3'd0, 1, 1, 64'h0000_0000_7FFF_FFFF, 64'h1);
    op_go(3'd0, 1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1);
    phase = "R9";
    wstat(5'b00010);
    phase = "R2";    // extended chain uses stored carry
    op_go(3'd2, 1, 0, 64'h5, 64'h6);
    op_go(3'd3, 1, 0, 64'h9, 64'h4);
    op_go(3'd1, 1, 1, 64'h1, 64'h0);
    phase = "R6";
    op_go(3'd4, 1, 1, 64'h8000_0000_0000_0000, 64'h0);
    wstat(5'b00011);
    op_go(3'd4, 1, 1, 64'h0000_0000_8000_0000, 64'h0);
    op_go(3'd4, 0, 1, 64'h0000_0000_8000_0000, 64'h0);
    phase = "R7";
    wstat(5'b00000);
    xov(1, 1, 1, 0);
    wstat(5'b00000);
    xov(1, 0, 1, 0);
    xov(1, 0, 0, 1);
    phase = "R10";
    wstat(5'b01100);
    op_go(3'd0, 1, 0, 64'h1, 64'h1);
    xov(0, 1, 1, 1);
    op_go(3'd7, 1, 1, '1, '1);
    idle();
    phase = "R8";    // sticky SO survives a clean overflow-enabled op
    op_go(3'd0, 0, 1, 64'h7FFF_FFFF, 64'h1);
    op_go(3'd0, 1, 1, 64'h1, 64'h1);
    wstat(5'b00000);
    phase = "R2";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      d_valid = ($urandom % 8) != 0;
      d_op = ($urandom % 10 < 8) ? 3'($urandom % 5) : 3'($urandom % 8);
      d_mode = $urandom; d_oe = $urandom;
      d_a = pick(); d_b = pick();
      d_dw = $urandom; d_e64 = $urandom; d_e32 = $urandom;
      d_wd = 5'($urandom);
    end
    idle();
    idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule